// File: doc/BRIEF.md
# Receiver Interrupt Status Controller

This block gathers event-driven status from a packet receiver into one 8-bit status register and drives an active-low interrupt line. The sources are an RX FIFO (its occupancy plus overflow, underflow and reset), an asynchronous external interrupt pin, and the packet engine (packet done, abort, sync word acknowledged, new packet start, CRC mismatch). Every flag has its own clear rule. There is no single write-1-to-clear path. A flag clears on a FIFO reset, on the occupancy dropping under a host-set threshold, on the next sync word, or on the next packet start.

The host writes the almost-full threshold through a write strobe. It supplies an enable mask that selects which status bits may pull the interrupt low. It reads the register directly from the status output. The bit positions are fixed because host software decodes them. Each event takes effect on the status register at the first rising clock edge that samples it.

Top module: `rxirq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit clears to 0 and the threshold clears to 0. With all flags low, `irq_n` is 1.
- R2: Bit 0 (CRC error) sets on the edge that samples `crc_bad`, clears on the edge that samples `pkt_start`, and otherwise holds. If both are sampled on the same edge, the set wins.
- R3: Bit 1 (packet valid) sets on the edge that samples `pkt_done` with `pkt_abort` low, clears on the edge that samples `sync_ack`, and otherwise holds. If set and clear are sampled on the same edge, the set wins. `pkt_done` together with `pkt_abort` does not set it.
- R4: Bits 2, 5 and 6 always read 0, whatever the inputs do.
- R5: Bit 3 equals the `ext_irq` input as sampled two rising edges earlier, through a two-stage synchronizer.
- R6: Bit 4 (almost full) is compared against the stored threshold. It becomes 1 when `fifo_level` is above the threshold and 0 when `fifo_level` is below it. When `fifo_level` equals the threshold, the bit keeps its value.
- R7: A write with `thr_we` high loads `thr_wdata` into the threshold at that edge. The compare made on that same edge still uses the old threshold.
- R8: Bit 7 (FIFO error) sets when `fifo_ovf` or `fifo_udf` is sampled. Only `fifo_rst` or `rst` clear it. If `fifo_rst` and an error event are sampled on the same edge, the clear wins.
- R9: `irq_n` is 0 exactly when the bitwise AND of the status register and `irq_mask` is non-zero. The output is combinational on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 8 | Count of unread bytes in the RX FIFO |
| fifo_ovf | input | 1 | FIFO overflow pulse |
| fifo_udf | input | 1 | FIFO underflow pulse |
| fifo_rst | input | 1 | FIFO reset pulse |
| ext_irq | input | 1 | Asynchronous external interrupt source |
| pkt_done | input | 1 | Packet fully received |
| pkt_abort | input | 1 | Reception aborted, qualifies `pkt_done` |
| sync_ack | input | 1 | Sync word of the next packet received and acknowledged |
| pkt_start | input | 1 | Reception of a new packet begins |
| crc_bad | input | 1 | Computed CRC differs from the received CRC |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold write data |
| irq_mask | input | 8 | Interrupt enable mask, one bit per status bit |
| status | output | 8 | Status register for host read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The embedded properties assume that event inputs are synchronous to `clk` and last a single cycle. They also assume that `fifo_level` changes only between edges, while `ext_irq` alone may move freely. The bench drives every input at the falling edge, so each event is seen by exactly one rising edge. It also changes the level only in whole steps across, onto and below the threshold. The bench covers coincident set/clear pairs and the write-then-compare ordering of the threshold on purpose. These are exactly the cases where the priority rules matter.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    localparam int STAT_W = 8;

    // bit positions decoded by host software
    localparam int B_CRC  = 0;
    localparam int B_PKV  = 1;
    localparam int B_EXT  = 3;
    localparam int B_AF   = 4;
    localparam int B_FERR = 7;

    typedef struct packed {
        logic       ferr;
        logic [1:0] rsv_hi;
        logic       afull;
        logic       ext;
        logic       rsv_lo;
        logic       pkv;
        logic       crc;
    } stat_t;

    typedef struct packed {
        logic crc;
        logic pkv;
        logic ferr;
    } evflags_t;

    function automatic stat_t build_status(evflags_t f, logic afull, logic ext);
        stat_t s;
        s.ferr   = f.ferr;
        s.rsv_hi = 2'b00;
        s.afull  = afull;
        s.ext    = ext;
        s.rsv_lo = 1'b0;
        s.pkv    = f.pkv;
        s.crc    = f.crc;
        return s;
    endfunction

    function automatic logic irq_active(stat_t s, logic [STAT_W-1:0] mask);
        return |(s & mask);
    endfunction

endpackage

// File: rtl/rxirq_sync.sv
module rxirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    p_sync_first_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> chain[0] == $past(d));
endmodule

// File: rtl/rxirq_level.sv
module rxirq_level #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             thr_we,
    input  logic [LVL_W-1:0] thr_wdata,
    output logic             afull
);
    logic [LVL_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            afull <= 1'b0;
        end else begin
            if (thr_we) thr_q <= thr_wdata;
            if (level > thr_q)      afull <= 1'b1;
            else if (level < thr_q) afull <= 1'b0;
        end
    end

    p_af_above_r6: assert property (@(posedge clk) disable iff (rst)
        (level > thr_q) |=> afull);
    p_af_below_r6: assert property (@(posedge clk) disable iff (rst)
        (level < thr_q) |=> !afull);
    p_af_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (level == thr_q) |=> $stable(afull));
    p_thr_load_r7: assert property (@(posedge clk) disable iff (rst)
        thr_we |=> thr_q == $past(thr_wdata));
endmodule

// File: rtl/rxirq_flags.sv
module rxirq_flags
    import rxirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     crc_bad,
    input  logic     pkt_start,
    input  logic     pkt_done,
    input  logic     pkt_abort,
    input  logic     sync_ack,
    input  logic     fifo_ovf,
    input  logic     fifo_udf,
    input  logic     fifo_rst,
    output evflags_t flags
);
    evflags_t nxt;

    always_comb begin
        nxt = flags;
        // set has priority over clear
        if (crc_bad)                   nxt.crc = 1'b1;
        else if (pkt_start)            nxt.crc = 1'b0;
        if (pkt_done && !pkt_abort)    nxt.pkv = 1'b1;
        else if (sync_ack)             nxt.pkv = 1'b0;
        // clear has priority over set
        if (fifo_rst)                  nxt.ferr = 1'b0;
        else if (fifo_ovf || fifo_udf) nxt.ferr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    p_crc_set_r2: assert property (@(posedge clk) disable iff (rst)
        crc_bad |=> flags.crc);
    p_crc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!crc_bad && !pkt_start) |=> $stable(flags.crc));
    p_pkv_set_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && !pkt_abort) |=> flags.pkv);
    p_pkv_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_ack && !pkt_done) |=> !flags.pkv);
    p_ferr_clr_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |=> !flags.ferr);
    p_ferr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flags.ferr && !fifo_rst) |=> flags.ferr);
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_ovf,
    input  logic              fifo_udf,
    input  logic              fifo_rst,
    input  logic              ext_irq,
    input  logic              pkt_done,
    input  logic              pkt_abort,
    input  logic              sync_ack,
    input  logic              pkt_start,
    input  logic              crc_bad,
    input  logic              thr_we,
    input  logic [LVL_W-1:0]  thr_wdata,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq_n
);
    evflags_t ev;
    logic     afull;
    logic     ext_s;
    stat_t    st;

    rxirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(ext_irq), .q(ext_s)
    );

    rxirq_level #(.LVL_W(LVL_W)) u_level (
        .clk(clk), .rst(rst), .level(fifo_level),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .afull(afull)
    );

    rxirq_flags u_flags (
        .clk(clk), .rst(rst),
        .crc_bad(crc_bad), .pkt_start(pkt_start),
        .pkt_done(pkt_done), .pkt_abort(pkt_abort), .sync_ack(sync_ack),
        .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf), .fifo_rst(fifo_rst),
        .flags(ev)
    );

    assign st     = build_status(ev, afull, ext_s);
    assign status = st;
    assign irq_n  = !irq_active(st, irq_mask);

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[2] == 1'b0 && status[6:5] == 2'b00));
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> irq_n);
endmodule

// File: tb/test_rxirq_ctrl.sv
module test_rxirq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fifo_level = '0;
    logic       fifo_ovf = 0, fifo_udf = 0, fifo_rst = 0, ext_irq = 0;
    logic       pkt_done = 0, pkt_abort = 0, sync_ack = 0, pkt_start = 0, crc_bad = 0;
    logic       thr_we = 0;
    logic [7:0] thr_wdata = '0;
    logic [7:0] irq_mask = '0;
    logic [7:0] status;
    logic       irq_n;

    always #2 clk = ~clk;

    rxirq_ctrl i_rxirq_ctrl (
        .clk(clk), .rst(rst), .fifo_level(fifo_level),
        .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf), .fifo_rst(fifo_rst),
        .ext_irq(ext_irq), .pkt_done(pkt_done), .pkt_abort(pkt_abort),
        .sync_ack(sync_ack), .pkt_start(pkt_start), .crc_bad(crc_bad),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .irq_mask(irq_mask),
        .status(status), .irq_n(irq_n)
    );

    typedef struct {
        logic [7:0] st;
        logic       irqn;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference state
    logic m_crc = 0, m_pkv = 0, m_af = 0, m_ferr = 0, m_e1 = 0, m_e2 = 0;
    logic [7:0] m_thr = '0;

    task automatic tick(string tag);
        exp_t e;
        if (rst) begin
            m_crc = 0; m_pkv = 0; m_af = 0; m_ferr = 0; m_e1 = 0; m_e2 = 0; m_thr = '0;
        end else begin
            if (crc_bad) m_crc = 1; else if (pkt_start) m_crc = 0;
            if (pkt_done && !pkt_abort) m_pkv = 1; else if (sync_ack) m_pkv = 0;
            if (fifo_rst) m_ferr = 0; else if (fifo_ovf || fifo_udf) m_ferr = 1;
            if (fifo_level > m_thr) m_af = 1; else if (fifo_level < m_thr) m_af = 0;
            if (thr_we) m_thr = thr_wdata;
            m_e2 = m_e1; m_e1 = ext_irq;
        end
        e.st   = {m_ferr, 2'b00, m_af, m_e2, 1'b0, m_pkv, m_crc};
        e.irqn = ((e.st & irq_mask) == 8'h00);
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic clr_pulses();
        fifo_ovf = 0; fifo_udf = 0; fifo_rst = 0; pkt_done = 0; pkt_abort = 0;
        sync_ack = 0; pkt_start = 0; crc_bad = 0; thr_we = 0;
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (status !== e.st || irq_n !== e.irqn) begin
                    n_fail++;
                    $display("FAIL %s: status=%02h irq_n=%b expected status=%02h irq_n=%b",
                             e.tag, status, irq_n, e.st, e.irqn);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        rst = 1; crc_bad = 1; fifo_ovf = 1; fifo_level = 8'd50; ext_irq = 1; irq_mask = 8'hFF;
        tick("R1"); tick("R1");
        clr_pulses(); ext_irq = 0; fifo_level = 0;
        tick("R1");
        rst = 0;
        tick("R1");

        // R2 CRC flag
        crc_bad = 1; tick("R2"); clr_pulses();
        tick("R2");
        pkt_start = 1; tick("R2"); clr_pulses();
        crc_bad = 1; pkt_start = 1; tick("R2 set wins"); clr_pulses();
        pkt_start = 1; tick("R2"); clr_pulses();

        // R3 packet valid
        pkt_done = 1; pkt_abort = 1; tick("R3 abort"); clr_pulses();
        pkt_done = 1; tick("R3"); clr_pulses();
        pkt_start = 1; tick("R3 hold"); clr_pulses();
        sync_ack = 1; tick("R3"); clr_pulses();
        pkt_done = 1; sync_ack = 1; tick("R3 set wins"); clr_pulses();
        sync_ack = 1; tick("R3"); clr_pulses();

        // R5 external synchronizer
        ext_irq = 1; tick("R5"); tick("R5"); tick("R5");
        ext_irq = 0; tick("R5"); tick("R5");

        // R6 / R7 almost full
        thr_we = 1; thr_wdata = 8'd10; tick("R7"); clr_pulses();
        fifo_level = 8'd11; tick("R6 above");
        fifo_level = 8'd10; tick("R6 equal hold");
        fifo_level = 8'd9;  tick("R6 below");
        fifo_level = 8'd10; tick("R6 equal hold");
        fifo_level = 8'd20; thr_we = 1; thr_wdata = 8'd30; tick("R7 old thr"); clr_pulses();
        tick("R7 new thr");
        fifo_level = 8'd31; tick("R6");
        fifo_level = 8'd0; tick("R6");

        // R8 FIFO error
        fifo_ovf = 1; tick("R8 ovf"); clr_pulses();
        pkt_start = 1; sync_ack = 1; tick("R8 sticky"); clr_pulses();
        fifo_rst = 1; tick("R8 clear"); clr_pulses();
        fifo_udf = 1; tick("R8 udf"); clr_pulses();
        fifo_udf = 1; fifo_rst = 1; tick("R8 reset wins"); clr_pulses();

        // R9 mask and R4 reserved bits
        crc_bad = 1; fifo_ovf = 1; irq_mask = 8'h00; tick("R9"); clr_pulses();
        irq_mask = 8'h02; tick("R9");
        irq_mask = 8'h64; tick("R4 R9 reserved mask");
        irq_mask = 8'h80; tick("R9");
        irq_mask = 8'h01; tick("R9");
        fifo_rst = 1; pkt_start = 1; tick("R9"); clr_pulses();
        irq_mask = 8'hFF; tick("R4");

        while (sb.size() > 0) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule